// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port Controller

This block is a general-purpose I/O port with 32 pins and a small register file. Each pin can be set as an output or an input. An output pin drives a value held in the port. An input pin is sampled through a synchronizer, and the same synchronized level feeds an edge detector. A detected edge of the selected kind latches an event bit. Software enables events through a mask. Every enabled, pending event is OR-ed onto one interrupt line.

Software reaches the port over a plain synchronous register bus. A write takes effect on the clock edge where the write enable is high. A read is combinational from the address.

A parameter picks one of two edge-control variants:
- The compact variant has one control bit per pin.
- The wide variant has a two-bit field per pin, spread over two control words. In this variant the four highest-numbered pins are fixed as inputs.

Pins are numbered from the most significant end: pin n lives in register bit 31 − n.

Top module: `irq_gpio_port`

## Requirements
- R1: After reset, every register reads zero, `pad_oe` is all zeros (every pin an input), `pad_o` is zero and `irq_o` is low.
- R2: The word at offset 0x00 holds the per-pin direction, where bit value 1 means output. `pad_oe` mirrors this word, `pad_o` mirrors the held data value, and the direction word changes only when it is written.
- R3: A read at offset 0x08 returns the held data bit for pins set as outputs. For pins set as inputs it returns the pad level, which the read shows two rising clock edges after the pad changes.
- R4: The event word at offset 0x0C is cleared by writing ones. A bit written as 1 clears that pin's event, a bit written as 0 leaves it unchanged, and writing all ones clears every event.
- R5: A selected edge on a pad sets that pin's event bit on the third rising clock edge after the pad changes.
- R6: The mask word at offset 0x10 enables a pin's event when its bit is 1. `irq_o` is high exactly when some event bit and its mask bit are both 1.
- R7: In the one-bit variant, bit 31 − n of the word at 0x14 controls pin n. Value 1 accepts only falling edges, and value 0 accepts both rising and falling edges.
- R8: In the two-bit variant, pins 0–15 use the word at 0x14 and pins 16–31 use the word at 0x18. The field for pin n sits at bits [2·(15 − n mod 16) +: 2]. Field value 0 accepts both edges, 1 accepts rising edges only, 2 accepts falling edges only, and 3 accepts no edge.
- R9: In the two-bit variant, the direction bits of pins 28–31 (bits 3:0) always read 0, whatever value is written to them.
- R10: When a pin's edge is detected in the same cycle that a write of 1 clears its event, the event bit stays set.
- R11: Offset 0x04, the unmapped offset 0x1C and, in the one-bit variant, offset 0x18 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_i | input | 32 | Pad input levels, bit 31 − n for pin n |
| pad_o | output | 32 | Driven output values |
| pad_oe | output | 32 | Output enables, 1 means the pad is driven |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds two copies side by side, one with the one-bit variant and one with the two-bit variant, both with 32 pins, two synchronizer stages and four input-only pins. Both copies see the same bus traffic and the same pad activity. This lets a single stimulus show how each variant decodes the edge-control words, how the second control word is ignored in one variant and stored in the other, and how the input-only direction bits are masked in the wide variant. The clear-versus-edge collision is placed on the exact edge where the synchronized level changes, so the test depends on the two-stage synchronizer depth.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int BUS_W  = 32;
   localparam int ADDR_W = 5;

   localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_EVT   = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h10;
   localparam logic [ADDR_W-1:0] OFS_CTL_A = 5'h14;
   localparam logic [ADDR_W-1:0] OFS_CTL_B = 5'h18;

   typedef enum logic {
      EDGE_CTL_1B = 1'b0,
      EDGE_CTL_2B = 1'b1
   } edge_ctl_e;

   typedef enum logic [1:0] {
      SEL_BOTH = 2'd0,
      SEL_RISE = 2'd1,
      SEL_FALL = 2'd2,
      SEL_NONE = 2'd3
   } edge_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Multi-stage pad synchronizer followed by a one-flop edge detector.
module gpio_in_sync #(
   parameter int NPINS  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pad_i,
   output logic [NPINS-1:0] lvl_o,
   output logic [NPINS-1:0] rise_o,
   output logic [NPINS-1:0] fall_o
);
   logic [STAGES-1:0][NPINS-1:0] chain_q;
   logic [NPINS-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= '0;
      end else begin
         chain_q[0] <= pad_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
         prev_q <= chain_q[STAGES-1];
      end
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/gpio_edge_sel.sv
// Turns raw edges into per-bit event set pulses according to the control words.
module gpio_edge_sel
   import gpio_irq_pkg::*;
#(
   parameter int        NPINS = 32,
   parameter edge_ctl_e MODE  = EDGE_CTL_1B
) (
   input  logic [NPINS-1:0] rise_i,
   input  logic [NPINS-1:0] fall_i,
   input  logic [BUS_W-1:0] ctl_a_i,
   input  logic [BUS_W-1:0] ctl_b_i,
   output logic [NPINS-1:0] set_o
);
   localparam int HALF = NPINS / 2;

   if (MODE == EDGE_CTL_1B) begin : g_one_bit
      logic unused_ctl_b;
      assign unused_ctl_b = ^ctl_b_i;
      for (genvar b = 0; b < NPINS; b++) begin : g_bit
         assign set_o[b] = ctl_a_i[b] ? fall_i[b] : (rise_i[b] | fall_i[b]);
      end
   end else begin : g_two_bit
      for (genvar b = 0; b < NPINS; b++) begin : g_bit
         logic [1:0] fld;
         if (b >= HALF) begin : g_hi
            assign fld = ctl_a_i[2*(b-HALF) +: 2];
         end else begin : g_lo
            assign fld = ctl_b_i[2*b +: 2];
         end
         assign set_o[b] = ((fld == SEL_BOTH) & (rise_i[b] | fall_i[b]))
                         | ((fld == SEL_RISE) & rise_i[b])
                         | ((fld == SEL_FALL) & fall_i[b]);
      end
   end
endmodule

// File: rtl/gpio_event_bank.sv
// Event latches with write-one-to-clear and the combined masked interrupt.
module gpio_event_bank #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] set_i,
   input  logic [NPINS-1:0] clr_i,
   input  logic [NPINS-1:0] mask_i,
   output logic [NPINS-1:0] evt_o,
   output logic             irq_o
);
   logic [NPINS-1:0] evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= (evt_q & ~clr_i) | set_i;
   end

   assign evt_o = evt_q;
   assign irq_o = |(evt_q & mask_i);

   // R4
   evt_w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(evt_q) & ~evt_q & ~$past(clr_i))) == 1'b0);

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(set_i) & ~evt_q)) == 1'b0);
endmodule

// File: rtl/irq_gpio_port.sv
// Memory-mapped GPIO port with per-pin direction, edge events and one interrupt.
module irq_gpio_port
   import gpio_irq_pkg::*;
#(
   parameter int        NPINS       = 32,
   parameter int        SYNC_STAGES = 2,
   parameter edge_ctl_e EDGE_MODE   = EDGE_CTL_1B,
   parameter int        INONLY_PINS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pad_i,
   output logic [NPINS-1:0]  pad_o,
   output logic [NPINS-1:0]  pad_oe,
   output logic              irq_o
);
   localparam logic [NPINS-1:0] INONLY_MASK =
      NPINS'((64'd1 << INONLY_PINS) - 64'd1);
   localparam logic [NPINS-1:0] DIR_WMASK =
      (EDGE_MODE == EDGE_CTL_2B) ? ~INONLY_MASK : {NPINS{1'b1}};

   if (NPINS < 2 || NPINS > BUS_W || (NPINS % 2) != 0)
      $error("NPINS must be even and between 2 and %0d", BUS_W);
   if (SYNC_STAGES < 2)
      $error("SYNC_STAGES must be at least 2");
   if (INONLY_PINS < 0 || INONLY_PINS > NPINS)
      $error("INONLY_PINS out of range");

   logic [NPINS-1:0] dir_q, out_q, mask_q;
   logic [BUS_W-1:0] ctl_a_q, ctl_b_q;
   logic [NPINS-1:0] lvl_v, rise_v, fall_v, set_v, evt_v, clr_v;
   logic             wr_dir, wr_data, wr_evt, wr_mask, wr_ctl_a;
   logic [BUS_W-1:0] rd_word;

   assign wr_dir   = bus_we && (bus_addr == OFS_DIR);
   assign wr_data  = bus_we && (bus_addr == OFS_DATA);
   assign wr_evt   = bus_we && (bus_addr == OFS_EVT);
   assign wr_mask  = bus_we && (bus_addr == OFS_MASK);
   assign wr_ctl_a = bus_we && (bus_addr == OFS_CTL_A);
   assign clr_v    = wr_evt ? bus_wdata[NPINS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         out_q   <= '0;
         mask_q  <= '0;
         ctl_a_q <= '0;
      end else begin
         if (wr_dir)   dir_q   <= bus_wdata[NPINS-1:0] & DIR_WMASK;
         if (wr_data)  out_q   <= bus_wdata[NPINS-1:0];
         if (wr_mask)  mask_q  <= bus_wdata[NPINS-1:0];
         if (wr_ctl_a) ctl_a_q <= bus_wdata;
      end
   end

   if (EDGE_MODE == EDGE_CTL_2B) begin : g_ctl_b
      logic wr_ctl_b;
      assign wr_ctl_b = bus_we && (bus_addr == OFS_CTL_B);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ctl_b_q <= '0;
         else if (wr_ctl_b) ctl_b_q <= bus_wdata;
      end
      // R9
      inonly_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dir_q & INONLY_MASK) == '0);
   end else begin : g_no_ctl_b
      assign ctl_b_q = '0;
      // R7
      fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|(set_v & ctl_a_q[NPINS-1:0] & ~fall_v)) == 1'b0);
   end

   gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad_i  (pad_i),
      .lvl_o  (lvl_v),
      .rise_o (rise_v),
      .fall_o (fall_v)
   );

   gpio_edge_sel #(.NPINS(NPINS), .MODE(EDGE_MODE)) u_edge (
      .rise_i  (rise_v),
      .fall_i  (fall_v),
      .ctl_a_i (ctl_a_q),
      .ctl_b_i (ctl_b_q),
      .set_o   (set_v)
   );

   gpio_event_bank #(.NPINS(NPINS)) u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .mask_i (mask_q),
      .evt_o  (evt_v),
      .irq_o  (irq_o)
   );

   always_comb begin
      rd_word = '0;
      case (bus_addr)
         OFS_DIR:   rd_word[NPINS-1:0] = dir_q;
         OFS_DATA:  rd_word[NPINS-1:0] = (out_q & dir_q) | (lvl_v & ~dir_q);
         OFS_EVT:   rd_word[NPINS-1:0] = evt_v;
         OFS_MASK:  rd_word[NPINS-1:0] = mask_q;
         OFS_CTL_A: rd_word = ctl_a_q;
         OFS_CTL_B: rd_word = ctl_b_q;
         default:   rd_word = '0;
      endcase
   end

   assign bus_rdata = rd_word;
   assign pad_o     = out_q;
   assign pad_oe    = dir_q;

   // R2
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!wr_dir) |-> $stable(dir_q));
endmodule

// File: tb/irq_gpio_port_bench.sv
module irq_gpio_port_bench;
   import gpio_irq_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] pads = '0;
   logic [31:0] rd0, rd1, po0, po1, oe0, oe1;
   logic        irq0, irq1;

   always #2 clk = ~clk;   // 250 MHz

   irq_gpio_port #(.EDGE_MODE(EDGE_CTL_1B)) u_irq_gpio_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rd0), .pad_i(pads), .pad_o(po0), .pad_oe(oe0), .irq_o(irq0));

   irq_gpio_port #(.EDGE_MODE(EDGE_CTL_2B)) u_irq_gpio_port_w2 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rd1), .pad_i(pads), .pad_o(po1), .pad_oe(oe1), .irq_o(irq1));

   // reference state built from the requirements
   logic [31:0] m_dir0 = '0, m_dir1 = '0, m_out = '0, m_mask = '0;
   logic [31:0] m_ctla = '0, m_ctlb1 = '0, m_evt0 = '0, m_evt1 = '0;

   typedef struct {
      logic [4:0]  a;
      logic [31:0] r0, r1, oe0, oe1, po;
      logic        i0, i1;
      string       tag;
   } item_t;
   item_t sbq[$];

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic cmp(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] edges(input bit two, input logic [31:0] o,
                                         input logic [31:0] n);
      logic [31:0] s = '0;
      for (int b = 0; b < 32; b++) begin
         logic r = n[b] & ~o[b];
         logic f = ~n[b] & o[b];
         logic [1:0] fld;
         if (!two) s[b] = m_ctla[b] ? f : (r | f);
         else begin
            fld = (b >= 16) ? m_ctla[2*(b-16) +: 2] : m_ctlb1[2*b +: 2];
            case (fld)
               2'd0: s[b] = r | f;
               2'd1: s[b] = r;
               2'd2: s[b] = f;
               default: s[b] = 1'b0;
            endcase
         end
      end
      return s;
   endfunction

   function automatic logic [31:0] exp_rd(input bit two, input logic [4:0] a);
      logic [31:0] d = two ? m_dir1 : m_dir0;
      case (a)
         5'h00: return d;
         5'h08: return (m_out & d) | (pads & ~d);
         5'h0C: return two ? m_evt1 : m_evt0;
         5'h10: return m_mask;
         5'h14: return m_ctla;
         5'h18: return two ? m_ctlb1 : 32'h0;
         default: return 32'h0;
      endcase
   endfunction

   // driver: one register write, reference state updated alongside
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      addr = a; we = 1'b1; wdata = d;
      @(posedge clk); #1;
      we = 1'b0;
      case (a)
         5'h00: begin m_dir0 = d; m_dir1 = d & 32'hFFFF_FFF0; end
         5'h08: m_out = d;
         5'h0C: begin m_evt0 &= ~d; m_evt1 &= ~d; end
         5'h10: m_mask = d;
         5'h14: m_ctla = d;
         5'h18: m_ctlb1 = d;
         default: ;
      endcase
   endtask

   task automatic set_pads(input logic [31:0] v);
      logic [31:0] old = pads;
      @(posedge clk); #1;
      pads = v;
      repeat (3) @(posedge clk);
      #1;
      m_evt0 |= edges(1'b0, old, v);
      m_evt1 |= edges(1'b1, old, v);
   endtask

   // driver: one read, expectation pushed to the scoreboard
   task automatic chk(input logic [4:0] a, input string tag);
      item_t it;
      @(posedge clk); #1;
      addr = a;
      it.a = a; it.tag = tag;
      it.r0 = exp_rd(1'b0, a); it.r1 = exp_rd(1'b1, a);
      it.oe0 = m_dir0; it.oe1 = m_dir1; it.po = m_out;
      it.i0 = |(m_evt0 & m_mask); it.i1 = |(m_evt1 & m_mask);
      sbq.push_back(it);
   endtask

   task automatic chk_all(input string tag);
      chk(5'h00, tag); chk(5'h04, tag); chk(5'h08, tag); chk(5'h0C, tag);
      chk(5'h10, tag); chk(5'h14, tag); chk(5'h18, tag); chk(5'h1C, tag);
   endtask

   // monitor: pops expectations and compares at the falling edge
   always @(negedge clk) begin
      item_t it;
      if (sbq.size() > 0) begin
         it = sbq.pop_front();
         cmp(it.tag, $sformatf("rd1b@%02h", it.a), rd0, it.r0);
         cmp(it.tag, $sformatf("rd2b@%02h", it.a), rd1, it.r1);
         cmp(it.tag, "irq1b", {31'b0, irq0}, {31'b0, it.i0});
         cmp(it.tag, "irq2b", {31'b0, irq1}, {31'b0, it.i1});
         cmp(it.tag, "oe1b", oe0, it.oe0);
         cmp(it.tag, "oe2b", oe1, it.oe1);
         cmp(it.tag, "po1b", po0, it.po);
         cmp(it.tag, "po2b", po1, it.po);
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk_all("R1");
      // R2 direction and pad enables, R9 input-only pins in two-bit variant
      wr(5'h00, 32'hFFFF_FFFF);
      chk_all("R2 R9");
      // R3 mixed data read
      wr(5'h00, 32'hFFFF_0000);
      wr(5'h08, 32'hA5A5_5A5A);
      set_pads(32'h1234_5678);
      chk_all("R3");
      // R11 reserved and unmapped offsets, R8 second control word
      wr(5'h04, 32'hFFFF_FFFF);
      wr(5'h1C, 32'hFFFF_FFFF);
      wr(5'h18, 32'h0000_00C3);
      chk_all("R11 R8");
      // R4 clear all, then R5/R6 with both edges enabled everywhere
      wr(5'h0C, 32'hFFFF_FFFF);
      wr(5'h14, 32'h0);
      wr(5'h18, 32'h0);
      wr(5'h10, 32'hFFFF_FFFF);
      chk(5'h0C, "R4");
      set_pads(~32'h1234_5678);
      chk_all("R5 R6");
      // R4 partial clear, zero write, full clear
      wr(5'h0C, 32'h0000_FFFF);
      chk(5'h0C, "R4");
      wr(5'h0C, 32'h0);
      chk(5'h0C, "R4");
      wr(5'h0C, 32'hFFFF_FFFF);
      chk(5'h0C, "R4");
      // R6 masking: pin 31 event masked, pin 0 event enabled
      wr(5'h10, 32'h8000_0000);
      set_pads(pads ^ 32'h0000_0001);
      chk(5'h0C, "R6");
      set_pads(pads ^ 32'h8000_0000);
      chk(5'h0C, "R6");
      // R7 / R8 alternate control patterns
      wr(5'h0C, 32'hFFFF_FFFF);
      wr(5'h10, 32'hFFFF_FFFF);
      wr(5'h14, 32'hAAAA_AAAA);
      wr(5'h18, 32'h5555_5555);
      set_pads(32'h0);
      chk_all("R7 R8");
      wr(5'h0C, 32'hFFFF_FFFF);
      set_pads(32'hFFFF_FFFF);
      chk_all("R7 R8");
      // R8 field value 3 accepts nothing
      wr(5'h0C, 32'hFFFF_FFFF);
      wr(5'h14, 32'hFFFF_FFFF);
      wr(5'h18, 32'hFFFF_0000);
      set_pads(32'h0);
      chk_all("R8 R7");
      // R10 edge and clear in the same cycle
      wr(5'h0C, 32'hFFFF_FFFF);
      wr(5'h14, 32'h0);
      wr(5'h18, 32'h0);
      set_pads(32'h0000_0020);
      chk(5'h0C, "R10");
      @(posedge clk); #1;
      pads = 32'h0;
      @(posedge clk);
      @(posedge clk); #1;
      addr = 5'h0C; we = 1'b1; wdata = 32'h0000_0020;
      @(posedge clk); #1;
      we = 1'b0;
      chk(5'h0C, "R10");
      wr(5'h0C, 32'h0000_0020);
      chk(5'h0C, "R10");
      repeat (3) @(posedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule